// File: doc/BRIEF.md
# Cascadable Serial Relay Control Register

This block holds the on/off state of a bank of relay enables and is loaded over a three-wire serial link: an active-low select, a serial clock and a serial data input. While the select is low, each rising edge of the serial clock pushes one data bit into a shift register, most significant bit first. The new pattern reaches the relay enables all at once, when the select returns high. The relay enables never change part way through a transfer.

A serial data output makes the register cascadable. On each falling serial-clock edge it shows the bit that entered eight rising edges earlier. Several blocks can therefore share one select and one clock, with each output feeding the next block's input. The whole chain is loaded in one select window.

All three serial pins are asynchronous to the block's system clock. They are brought into the system clock domain through a synchronizer, and their edges are found there. The system clock must run at least four times faster than the serial clock.

Top module: `relay_ser_ctrl`

## Requirements
- R1: Register bit k drives `relay_on[k]`. The first bit shifted in a full 8-bit transfer lands in bit 7 (`relay_on[7]`), and the last lands in bit 0.
- R2: While `sel_n` is low, every rising edge of `sclk` shifts the register up by one and places `sdi` in bit 0.
- R3: While `sel_n` is low, `sdo` is updated on each falling edge of `sclk` to the register's bit 7. `sdo` therefore repeats the `sdi` stream eight serial clocks later.
- R4: A rising edge of `sel_n` copies the shift register into `relay_on`. This happens whether `sclk` is high or low at that moment.
- R5: `relay_on` does not change while `sel_n` is low.
- R6: While `sel_n` is high, activity on `sclk` and `sdi` changes neither the shift register nor `relay_on`.
- R7: A select window with more than eight clocks leaves only the last eight bits in the register. A window with fewer than eight clocks shifts the older contents up by the number of clocks.
- R8: While `sel_n` is high, `sdo` shows bit 7 of the shift register.
- R9: A synchronous reset `rst` clears the shift register, `relay_on` and `sdo` to zero.
- R10: `relay_on` reflects a `sel_n` rising edge no more than 4 system clock cycles after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Active-low select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, sampled on `sclk` rising |
| sdo | output | 1 | Cascade data out |
| relay_on | output | NUM_CH | Relay enables; bit k is relay k+1 |

## Verification
Most internal faults in this block show up at `sdo` within one serial clock period. A wrong shift direction, a dropped or duplicated shift, or a misrouted data bit changes the cascade stream on the next falling `sclk` edge. A wrong shift enable shows on `sdo` even while the block is deselected, because `sdo` then tracks bit 7 directly. Faults in the output latch stay hidden until the next `sel_n` rising edge. At that edge the whole 8-bit pattern appears on `relay_on` within four system clocks. A latch that loads at the wrong time shows as `relay_on` moving during a transfer.

// File: rtl/relay_ser_pkg.sv
package relay_ser_pkg;
  // lane positions inside the synchronized serial pin vector
  localparam int LANE_SDI  = 0;
  localparam int LANE_SCLK = 1;
  localparam int LANE_SEL  = 2;
  localparam int N_LANES   = 3;
  // idle levels of the pins: select released, clock low, data low
  localparam logic [N_LANES-1:0] PIN_IDLE = 3'b100;
endpackage

// File: rtl/sr_sync_vec.sv
module sr_sync_vec #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sr_edge_det.sv
module sr_edge_det #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise[g] = lvl[g] & ~prev[g];
    assign fall[g] = ~lvl[g] & prev[g];
  end
endmodule

// File: rtl/sr_shift_chain.sv
module sr_shift_chain #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         drive_en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         sdo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      sdo <= 1'b0;
    end else begin
      if (shift_en) q <= {q[W-2:0], din};
      if (drive_en) sdo <= q[W-1];
    end
  end
endmodule

// File: rtl/sr_out_latch.sv
module sr_out_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/relay_ser_ctrl.sv
module relay_ser_ctrl
  import relay_ser_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic [NUM_CH-1:0] relay_on
);
  localparam int NE = 2; // edge lanes: 0 = sclk, 1 = select
  localparam logic [NE-1:0] EDGE_IDLE = {PIN_IDLE[LANE_SEL], PIN_IDLE[LANE_SCLK]};

  logic [N_LANES-1:0] pins_raw, pins_s;
  logic [NE-1:0]      e_rise, e_fall;
  logic               sel_s, din_s, sclk_rise, sclk_fall, sel_rise;
  logic [NUM_CH-1:0]  shreg;

  always_comb begin
    pins_raw = '0;
    pins_raw[LANE_SDI]  = sdi;
    pins_raw[LANE_SCLK] = sclk;
    pins_raw[LANE_SEL]  = sel_n;
  end

  sr_sync_vec #(.W(N_LANES), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  assign sel_s = pins_s[LANE_SEL];
  assign din_s = pins_s[LANE_SDI];

  sr_edge_det #(.W(NE), .RST_VAL(EDGE_IDLE)) u_edge (
    .clk(clk), .rst(rst),
    .lvl({pins_s[LANE_SEL], pins_s[LANE_SCLK]}),
    .rise(e_rise), .fall(e_fall)
  );

  assign sclk_rise = e_rise[0];
  assign sclk_fall = e_fall[0];
  assign sel_rise  = e_rise[1];

  sr_shift_chain #(.W(NUM_CH)) u_shift (
    .clk(clk), .rst(rst),
    .shift_en(sclk_rise & ~sel_s),
    .drive_en((sclk_fall & ~sel_s) | sel_s),
    .din(din_s),
    .q(shreg),
    .sdo(sdo)
  );

  sr_out_latch #(.W(NUM_CH)) u_latch (
    .clk(clk), .rst(rst), .load(sel_rise), .d(shreg), .q(relay_on)
  );
endmodule

// File: rtl/relay_ser_ctrl_chk.sv
module relay_ser_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_s,
  input logic         sclk_rise,
  input logic         din_s,
  input logic [W-1:0] shreg,
  input logic [W-1:0] relay_on,
  input logic         sdo
);
  logic sel_prev;
  always_ff @(posedge clk) begin
    if (rst) sel_prev <= 1'b1;
    else     sel_prev <= sel_s;
  end

  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !sel_s) |=> (shreg[0] == $past(din_s)));

  p_latch_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_s && !sel_prev) |=> (relay_on == $past(shreg)));

  p_hold_sel_low_r5: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> $stable(relay_on));

  p_idle_no_shift_r6: assert property (@(posedge clk) disable iff (rst)
    sel_s |=> $stable(shreg));

  p_idle_sdo_msb_r8: assert property (@(posedge clk) disable iff (rst)
    (sel_s && sel_prev) |-> (sdo == shreg[W-1]));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (relay_on == '0 && shreg == '0 && sdo == 1'b0));
endmodule

bind relay_ser_ctrl relay_ser_ctrl_chk #(.W(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .sel_s(sel_s), .sclk_rise(sclk_rise),
  .din_s(din_s), .shreg(shreg), .relay_on(relay_on), .sdo(sdo)
);

// File: tb/relay_ser_ctrl_bench.sv
module relay_ser_ctrl_bench;
  localparam int N = 8;
  localparam int HALF = 8; // system clocks per serial half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic [N-1:0] relay_on;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [N-1:0] m_sh = '0;
  logic [N-1:0] m_lat = '0;

  always #2 clk = ~clk; // 250 MHz

  relay_ser_ctrl u_relay_ser_ctrl (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .relay_on(relay_on)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit; checks sdo after the falling edge (R3)
  task automatic send_bit(input logic b);
    sdi = b;
    wait_sys(HALF);
    sclk = 1'b1;
    m_sh = {m_sh[N-2:0], b};
    wait_sys(HALF);
    sclk = 1'b0;
    wait_sys(HALF);
    check("R3 sdo after falling sclk", {7'b0, sdo}, {7'b0, m_sh[N-1]});
  endtask

  task automatic send_bits(input logic [15:0] v, input int cnt);
    for (int i = cnt - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic release_sel();
    sel_n = 1'b1;
    m_lat = m_sh;
    wait_sys(4);
    check("R10 relay_on within 4 cycles of select release", relay_on, m_lat);
    wait_sys(HALF);
    check("R8 sdo shows register bit 7 while deselected", {7'b0, sdo}, {7'b0, m_sh[N-1]});
  endtask

  task automatic t_reset();
    check("R9 relay_on after reset", relay_on, '0);
    check("R9 sdo after reset", {7'b0, sdo}, '0);
  endtask

  task automatic t_full_write();
    sel_n = 1'b0; wait_sys(HALF);
    send_bits(16'h00A5, 8);
    check("R5 relays held during transfer", relay_on, '0);
    release_sel();
    check("R1 first bit drives relay_on[7]", {7'b0, relay_on[7]}, 8'd1);
    check("R1 pattern A5 on relays", relay_on, 8'hA5);
  endtask

  task automatic t_hold_and_echo();
    sel_n = 1'b0; wait_sys(HALF);
    // first 8 falls echo old contents A5, next 8 carry new stream (R3)
    send_bits(16'h3C81, 16);
    check("R5 relays keep A5 while selected", relay_on, 8'hA5);
    release_sel();
    check("R7 only last 8 of 16 bits kept", relay_on, 8'h81);
  endtask

  task automatic t_short_write();
    sel_n = 1'b0; wait_sys(HALF);
    send_bits(16'h0005, 3);
    release_sel();
    check("R7 three bits shift old contents up", relay_on, 8'h0D);
  endtask

  task automatic t_idle_activity();
    for (int i = 0; i < 6; i++) begin
      sdi = i[0];
      wait_sys(HALF); sclk = 1'b1;
      wait_sys(HALF); sclk = 1'b0;
    end
    wait_sys(HALF);
    check("R6 relays unchanged by deselected clocks", relay_on, m_lat);
    check("R6 sdo unchanged by deselected clocks", {7'b0, sdo}, {7'b0, m_sh[N-1]});
    sel_n = 1'b0; wait_sys(HALF);
    release_sel();
    check("R6 register unchanged by deselected clocks", relay_on, 8'h0D);
  endtask

  task automatic t_release_sclk_high();
    sel_n = 1'b0; wait_sys(HALF);
    send_bits(16'h0062, 7);
    sdi = 1'b1;
    wait_sys(HALF);
    sclk = 1'b1;
    m_sh = {m_sh[N-2:0], 1'b1};
    wait_sys(HALF);
    check("R2 rising edge shift not yet on relays", relay_on, 8'h0D);
    release_sel();
    sclk = 1'b0;
    wait_sys(HALF);
    check("R4 latch with sclk high", relay_on, 8'hC5);
    check("R2 MSB-first order", relay_on, m_sh);
  endtask

  task automatic t_mid_reset();
    sel_n = 1'b0; wait_sys(HALF);
    send_bits(16'h00FF, 4);
    sel_n = 1'b1;
    rst = 1'b1;
    wait_sys(3);
    rst = 1'b0;
    m_sh = '0; m_lat = '0;
    wait_sys(HALF);
    check("R9 relays cleared by reset", relay_on, '0);
    check("R9 sdo cleared by reset", {7'b0, sdo}, '0);
    sel_n = 1'b0; wait_sys(HALF);
    release_sel();
    check("R9 register cleared by reset", relay_on, '0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait_sys(5);
    rst = 1'b0;
    wait_sys(5);
    t_reset();
    t_full_write();
    t_hold_and_echo();
    t_short_write();
    t_idle_activity();
    t_release_sclk_high();
    t_mid_reset();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule